// File: doc/BRIEF.md
# Power-Save and Static Indicator Controller

This block sits behind the command decoder of a dot-matrix display controller and watches the stream of control bytes sent by the host. It keeps the display-enable flag, the all-pixels-forced flag and the static indicator settings. From these it works out the power state of the panel: normal, sleep or standby. It then drives the enables for the display oscillator, the panel supply generators and the row/column matrix drivers.

Power save is reached through a compound of two commands. The host first turns the display off, then forces all pixels on. The indicator mode in effect at that moment decides the result. With the mode off the panel goes to sleep, where everything stops. With the mode on it goes to standby, where the oscillator keeps running so that the single static indicator segment can still be driven. Forcing all pixels off returns the panel to normal.

The static indicator command takes two bytes. The first byte switches indicator mode on or off. When it switches the mode on, the byte that follows is taken as a 2-bit indicator state and is not decoded as a command. The indicator output can be off, steadily on, or blinking at one of two rates. The blink rates are derived from a prescaler that counts quarter-second intervals of the system clock.

Top module: `psi_ctrl_top`

## Requirements
- R1: After hardware reset the display flag, forced-pixels flag and indicator mode are 0, the indicator state is 00, the power state is normal (ps_state_o = 00), the oscillator, supply and driver enables are all 1, and ind_o is 0.
- R2: Byte 0xAF sets the display flag and 0xAE clears it. Byte 0xA5 sets the forced-pixels flag and 0xA4 clears it. Each change is visible on the outputs after the clock edge that samples the byte.
- R3: In normal state, 0xA5 received while the display flag is 0 and indicator mode is 0 enters sleep (ps_state_o = 01). In sleep the oscillator, supply and driver enables are all 0 and ind_o is 0.
- R4: In normal state, 0xA5 received while the display flag is 0 and indicator mode is 1 enters standby (ps_state_o = 10). In standby the oscillator enable is 1, the supply and driver enables are 0, and ind_o follows the indicator setting.
- R5: 0xA5 received while the display flag is 1 sets only the forced-pixels flag, and the state stays normal.
- R6: 0xA4 received in sleep or standby returns the state to normal.
- R7: The soft-reset byte 0xE2 moves standby to sleep. In normal or sleep state it changes nothing observable.
- R8: 0xAD turns indicator mode on and arms a load. The next byte then sets the indicator state from its bits [1:0], whatever its other bits are, and has no other effect. 0xAC turns indicator mode off and arms nothing.
- R9: When indicator mode is 1 and the state is not sleep, indicator state 00 gives ind_o = 0 and 11 gives ind_o = 1 steadily. When indicator mode is 0, ind_o is 0.
- R10: Indicator state 01 blinks with ind_o high for 2·QTR_CYC cycles and then low for 2·QTR_CYC cycles, starting high at the edge that loads the state.
- R11: Indicator state 10 blinks with ind_o high for QTR_CYC cycles and then low for QTR_CYC cycles, starting high at the edge that loads the state.
- R12: Once in sleep or standby, changing indicator mode does not switch between the two. Only 0xA4 (R6) and 0xE2 (R7) change the power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| cmd_valid | input | 1 | Control byte present this cycle |
| cmd_byte | input | 8 | Control byte from the host interface |
| disp_on_o | output | 1 | Display enable flag |
| all_on_o | output | 1 | Forced all-pixels-on flag |
| ps_state_o | output | 2 | Power state: 00 normal, 01 sleep, 10 standby |
| osc_en_o | output | 1 | Display oscillator enable |
| lcd_pwr_en_o | output | 1 | Panel supply generator enable |
| drv_en_o | output | 1 | Row/column matrix driver enable |
| ind_o | output | 1 | Static indicator drive |

## Verification
The bench sets QTR_CYC to 3 and selects the restart-on-load variant. With these values a full slow blink period lasts 12 cycles and a fast period lasts 6 cycles, so the bench can follow every phase edge of both blink rates cycle by cycle from a known start. The default QTR_CYC of 50,000,000 makes a single blink phase far longer than any run. Under these settings the bench visits every power-state transition, and it feeds state bytes that look like display, pixel-forcing and soft-reset commands to show that an armed load takes precedence.

// File: rtl/psi_pkg.sv
package psi_pkg;

   typedef enum logic [1:0] {
      PS_NORMAL  = 2'b00,
      PS_SLEEP   = 2'b01,
      PS_STANDBY = 2'b10
   } ps_state_e;

   // upper seven bits of the toggle-style commands; bit 0 carries the value
   localparam logic [6:0] CMD_DISP_HI = 7'b1010111;
   localparam logic [6:0] CMD_FILL_HI = 7'b1010010;
   localparam logic [6:0] CMD_IND_HI  = 7'b1010110;
   localparam logic [7:0] CMD_SRST    = 8'hE2;

   localparam int unsigned IND_W = 2;

endpackage

// File: rtl/psi_cmd_decode.sv
module psi_cmd_decode
   import psi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [7:0]       cmd_byte,
   output logic             disp_on_o,
   output logic             all_on_o,
   output logic             ind_mode_o,
   output logic [IND_W-1:0] ind_state_o,
   output logic             fill_on_stb_o,
   output logic             fill_off_stb_o,
   output logic             srst_stb_o,
   output logic             load_stb_o
);

   logic armed_q;
   logic free_byte;
   logic is_disp, is_fill, is_ind;

   always_comb begin
      free_byte      = cmd_valid & ~armed_q;
      is_disp        = free_byte && (cmd_byte[7:1] == CMD_DISP_HI);
      is_fill        = free_byte && (cmd_byte[7:1] == CMD_FILL_HI);
      is_ind         = free_byte && (cmd_byte[7:1] == CMD_IND_HI);
      fill_on_stb_o  = is_fill &  cmd_byte[0];
      fill_off_stb_o = is_fill & ~cmd_byte[0];
      srst_stb_o     = free_byte && (cmd_byte == CMD_SRST);
      load_stb_o     = cmd_valid & armed_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_on_o   <= 1'b0;
         all_on_o    <= 1'b0;
         ind_mode_o  <= 1'b0;
         ind_state_o <= '0;
         armed_q     <= 1'b0;
      end else begin
         if (is_disp) disp_on_o <= cmd_byte[0];
         if (is_fill) all_on_o  <= cmd_byte[0];
         if (is_ind) begin
            ind_mode_o <= cmd_byte[0];
            armed_q    <= cmd_byte[0];
         end
         if (load_stb_o) begin
            ind_state_o <= cmd_byte[IND_W-1:0];
            armed_q     <= 1'b0;
         end
      end
   end

   AST_STATE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ind_state_o) |-> $past(armed_q && cmd_valid)); // R8

   AST_ARMED_BYTE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(armed_q && cmd_valid) |-> ($stable(disp_on_o) && $stable(all_on_o))); // R8

endmodule

// File: rtl/psi_power_fsm.sv
module psi_power_fsm
   import psi_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      fill_on_stb,
   input  logic      fill_off_stb,
   input  logic      srst_stb,
   input  logic      disp_on,
   input  logic      ind_mode,
   output ps_state_e state_o
);

   ps_state_e state_d;

   always_comb begin
      state_d = state_o;
      unique case (state_o)
         PS_NORMAL: begin
            if (fill_on_stb && !disp_on)
               state_d = ind_mode ? PS_STANDBY : PS_SLEEP;
         end
         PS_SLEEP: begin
            if (fill_off_stb) state_d = PS_NORMAL;
         end
         PS_STANDBY: begin
            if (fill_off_stb)  state_d = PS_NORMAL;
            else if (srst_stb) state_d = PS_SLEEP;
         end
         default: state_d = PS_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= PS_NORMAL;
      else        state_o <= state_d;
   end

   AST_ENTRY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != PS_NORMAL && $past(state_o) == PS_NORMAL)
      |-> $past(fill_on_stb && !disp_on)); // R3

   AST_KIND_BY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == PS_STANDBY && $past(state_o) == PS_NORMAL) |-> $past(ind_mode)); // R4

   AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == PS_NORMAL && $past(state_o) != PS_NORMAL) |-> $past(fill_off_stb)); // R6

   AST_STBY_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == PS_SLEEP && $past(state_o) == PS_STANDBY) |-> $past(srst_stb)); // R7

   AST_NO_WAKE_TO_STBY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_o) == PS_SLEEP) |-> (state_o != PS_STANDBY)); // R12

endmodule

// File: rtl/psi_blink_gen.sv
module psi_blink_gen
   import psi_pkg::*;
#(
   parameter int unsigned QTR_CYC         = 50_000_000,
   parameter bit          RESTART_ON_LOAD = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [IND_W-1:0] ind_state,
   output logic             wave_o
);

   localparam int unsigned PRE_W   = (QTR_CYC > 2) ? $clog2(QTR_CYC) : 1;
   localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(QTR_CYC - 1);

   if (QTR_CYC < 2) begin : g_bad_qtr
      $error("psi_blink_gen: QTR_CYC must be at least 2");
   end

   logic [PRE_W-1:0] pre_q;
   logic [1:0]       qtr_q;
   logic             wrap;

   assign wrap = (pre_q == PRE_MAX);

   if (RESTART_ON_LOAD) begin : g_restart
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
            qtr_q <= '0;
         end else if (restart) begin
            pre_q <= '0;
            qtr_q <= '0;
         end else if (wrap) begin
            pre_q <= '0;
            qtr_q <= qtr_q + 2'd1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end

      AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(qtr_q) |-> ($past(wrap) || $past(restart))); // R11
   end else begin : g_free
      logic unused_restart;
      assign unused_restart = restart;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
            qtr_q <= '0;
         end else if (wrap) begin
            pre_q <= '0;
            qtr_q <= qtr_q + 2'd1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end

      AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(qtr_q) |-> $past(wrap)); // R11
   end

   always_comb begin
      unique case (ind_state)
         2'b00:   wave_o = 1'b0;
         2'b01:   wave_o = ~qtr_q[1];
         2'b10:   wave_o = ~qtr_q[0];
         default: wave_o = 1'b1;
      endcase
   end

   AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= PRE_MAX); // R10

endmodule

// File: rtl/psi_ctrl_top.sv
module psi_ctrl_top
   import psi_pkg::*;
#(
   parameter int unsigned QTR_CYC         = 50_000_000,
   parameter bit          RESTART_ON_LOAD = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_byte,
   output logic       disp_on_o,
   output logic       all_on_o,
   output logic [1:0] ps_state_o,
   output logic       osc_en_o,
   output logic       lcd_pwr_en_o,
   output logic       drv_en_o,
   output logic       ind_o
);

   logic             ind_mode;
   logic [IND_W-1:0] ind_state;
   logic             fill_on_stb, fill_off_stb, srst_stb, load_stb;
   logic             wave;
   ps_state_e        ps;

   psi_cmd_decode u_dec (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_valid      (cmd_valid),
      .cmd_byte       (cmd_byte),
      .disp_on_o      (disp_on_o),
      .all_on_o       (all_on_o),
      .ind_mode_o     (ind_mode),
      .ind_state_o    (ind_state),
      .fill_on_stb_o  (fill_on_stb),
      .fill_off_stb_o (fill_off_stb),
      .srst_stb_o     (srst_stb),
      .load_stb_o     (load_stb)
   );

   psi_power_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .fill_on_stb  (fill_on_stb),
      .fill_off_stb (fill_off_stb),
      .srst_stb     (srst_stb),
      .disp_on      (disp_on_o),
      .ind_mode     (ind_mode),
      .state_o      (ps)
   );

   psi_blink_gen #(
      .QTR_CYC         (QTR_CYC),
      .RESTART_ON_LOAD (RESTART_ON_LOAD)
   ) u_blink (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (load_stb),
      .ind_state (ind_state),
      .wave_o    (wave)
   );

   always_comb begin
      unique case (ps)
         PS_NORMAL:  {osc_en_o, lcd_pwr_en_o, drv_en_o} = 3'b111;
         PS_STANDBY: {osc_en_o, lcd_pwr_en_o, drv_en_o} = 3'b100;
         default:    {osc_en_o, lcd_pwr_en_o, drv_en_o} = 3'b000;
      endcase
      ps_state_o = ps;
      ind_o      = ind_mode & wave & (ps != PS_SLEEP);
   end

   AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_state_o == 2'b01) |-> (!ind_o && !osc_en_o && !lcd_pwr_en_o)); // R3

   AST_STBY_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_state_o == 2'b10) |-> (osc_en_o && !drv_en_o)); // R4

endmodule

// File: tb/psi_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module psi_ctrl_top_tb_top;

   localparam int Q = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       disp_on_o, all_on_o, osc_en_o, lcd_pwr_en_o, drv_en_o, ind_o;
   logic [1:0] ps_state_o;

   always #2.5 clk = ~clk;

   psi_ctrl_top #(.QTR_CYC(Q), .RESTART_ON_LOAD(1'b1)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_byte     (cmd_byte),
      .disp_on_o    (disp_on_o),
      .all_on_o     (all_on_o),
      .ps_state_o   (ps_state_o),
      .osc_en_o     (osc_en_o),
      .lcd_pwr_en_o (lcd_pwr_en_o),
      .drv_en_o     (drv_en_o),
      .ind_o        (ind_o)
   );

   typedef struct {
      string      tag;
      logic [7:0] vec;   // {ps[1:0], disp, all, osc, pwr, drv, ind}
   } exp_t;

   exp_t sbq[$];
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   // reference model, written from the requirements
   int         cyc = 0;
   int         load_cyc = 0;
   logic [1:0] m_ps = 2'b00;
   logic       m_disp = 1'b0, m_all = 1'b0, m_mode = 1'b0, m_armed = 1'b0;
   logic [1:0] m_ind = 2'b00;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic wave_f(logic [1:0] st, int n);
      int ph;
      ph = (n / Q) % 4;
      case (st)
         2'b00:   return 1'b0;
         2'b01:   return (ph < 2);
         2'b10:   return ((ph % 2) == 0);
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [7:0] model_vec();
      logic [2:0] en;
      logic       ind;
      case (m_ps)
         2'b00:   en = 3'b111;
         2'b10:   en = 3'b100;
         default: en = 3'b000;
      endcase
      ind = m_mode && (m_ps != 2'b01) && wave_f(m_ind, cyc - load_cyc);
      return {m_ps, m_disp, m_all, en, ind};
   endfunction

   task automatic push(string tag);
      exp_t e;
      e.tag = tag;
      e.vec = model_vec();
      sbq.push_back(e);
   endtask

   task automatic send(logic [7:0] b, string tag);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_byte  = b;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
      if (m_armed) begin
         m_ind    = b[1:0];
         m_armed  = 1'b0;
         load_cyc = cyc;
      end else begin
         case (b)
            8'hAE, 8'hAF: m_disp = b[0];
            8'hA4: begin m_all = 1'b0; m_ps = 2'b00; end
            8'hA5: begin
               if (!m_disp && m_ps == 2'b00) m_ps = m_mode ? 2'b10 : 2'b01;
               m_all = 1'b1;
            end
            8'hAC, 8'hAD: begin m_mode = b[0]; m_armed = b[0]; end
            8'hE2: if (m_ps == 2'b10) m_ps = 2'b01;
            default: ;
         endcase
      end
      push(tag);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
         push(tag);
      end
   endtask

   // monitor: pops expected items and compares at the falling edge
   always @(negedge clk) begin
      if (sbq.size() > 0) begin
         exp_t e;
         logic [7:0] act;
         e   = sbq.pop_front();
         act = {ps_state_o, disp_on_o, all_on_o, osc_en_o, lcd_pwr_en_o, drv_en_o, ind_o};
         n_run++;
         if (act !== e.vec) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (ps,disp,all,osc,pwr,drv,ind)",
                     e.tag, act, e.vec);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      push("R1 reset state");

      send(8'hAF, "R2 display on");
      send(8'hA5, "R5 fill with display on stays normal");
      send(8'hA4, "R2 fill off");
      send(8'hAE, "R2 display off");
      send(8'hE2, "R7 soft reset in normal no effect");
      send(8'hA5, "R3 dark fill enters sleep");
      idle(2,      "R3 sleep holds");
      send(8'hE2, "R7 soft reset in sleep no effect");
      send(8'hAD, "R8 mode on arms load");
      send(8'hAF, "R8 armed byte loads state 11 only");
      send(8'hA4, "R6 release sleep");
      idle(2,      "R9 steady on");
      send(8'hA5, "R4 dark fill with mode enters standby");
      send(8'hAC, "R12 mode off keeps standby");
      send(8'hAD, "R12 mode on keeps standby");
      send(8'hE2, "R8 armed soft-reset byte loads state 10");
      idle(2 * Q,  "R11 fast blink in standby");
      send(8'hE2, "R7 standby to sleep");
      send(8'hAD, "R12 mode on in sleep keeps sleep");
      send(8'hA5, "R8 armed fill byte loads 01 only");
      send(8'hA4, "R6 release to normal");
      idle(4 * Q + 2, "R10 slow blink");
      send(8'hAD, "R8 arm");
      send(8'h02, "R11 load fast");
      idle(3 * Q,  "R11 fast blink");
      send(8'hAD, "R8 arm");
      send(8'h00, "R9 state 00 dark");
      idle(2,      "R9 state 00 dark");
      send(8'hAD, "R8 arm");
      send(8'h03, "R9 state 11");
      send(8'hAC, "R9 mode off dark");
      send(8'hAD, "R8 arm");
      send(8'hA4, "R8 armed A4 byte loads 00 keeps normal");
      send(8'hAF, "R2 display on");
      send(8'hA5, "R5 fill with display on stays normal");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule